// File: doc/BRIEF.md
# Ultra DMA Write-Burst Termination Controller

This block is the device-side controller that ends a host-to-device Ultra DMA burst on the device's own initiative. Inside a burst it captures one 16-bit word on each edge of the host strobe. When the device core requests termination, the block withdraws its ready signal first. It accepts a bounded number of trailing words. It drops the DMA request after a programmable hold time and waits for the host to raise STOP. A strobe edge that follows this point carries no data, so the block does not capture it. The block latches the host's CRC word when the host deasserts its acknowledge, and then releases its strobe driver.

A local CRC (polynomial x^16+x^12+x^5+1, seed 16'h4ABA, data bits taken most significant first) is reseeded at each burst and updated on every accepted word. A sticky error flag keeps the host CRC value of the first miscompare seen in a command. Only a new-command pulse clears the flag. The host strobe, STOP and acknowledge inputs pass through two-flop synchronizers. All minimum delays are parameters counted in clock cycles.

Top module: `udmaWriteTerm`

## Requirements
- R1: A termination request (termReq high) has no effect until at least one word has been captured in the current burst; devRdy stays high until then.
- R2: Termination starts with devRdy falling while dmaReq and strbOe are still high.
- R3: After devRdy falls, up to 2 further words are accepted when fastMode is 0, and up to 3 further words when fastMode is 1. Strobe edges beyond that limit produce no wordValid and do not change the CRC.
- R4: dmaReq falls RP_CYC or more clock cycles after devRdy falls, and it is not raised again before the burst has ended (the done pulse).
- R5: Once dmaReq is low, no strobe edge captures a word, including the host's final strobe rise. The controller waits for hostStop high before it accepts the acknowledge deassertion.
- R6: On the rising edge of hostAckN (active-low acknowledge deasserted), the controller latches dataIn as the host CRC and compares it with the local CRC. The local CRC is seeded with 16'h4ABA at burstStart and is updated MSB first with polynomial 16'h1021 over every accepted word, trailing words included.
- R7: crcErr is set on the first miscompare and stays set across later bursts. errCrc holds the host CRC of that first miscompare. Both clear only on newCmd.
- R8: strbOe falls REL_CYC cycles after the controller sees the acknowledge deassert. done pulses for one cycle in the same cycle that strbOe falls.
- R9: After reset, devRdy, dmaReq, strbOe, wordValid, crcErr and done are all low.
- R10: While the burst is active, each edge of hostStrobe (rising or falling) produces exactly one wordValid pulse, with wordData equal to dataIn at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| newCmd | input | 1 | Pulse at command start; clears the error record |
| burstStart | input | 1 | Pulse opening a burst; reseeds the CRC |
| termReq | input | 1 | Device core asks to end the burst |
| fastMode | input | 1 | 1 for modes 3/4 (3 trailing words), 0 for modes 0-2 (2 trailing words) |
| hostStrobe | input | 1 | Host data strobe, asynchronous |
| hostStop | input | 1 | Host STOP, asynchronous |
| hostAckN | input | 1 | Host DMA acknowledge, active low, asynchronous |
| dataIn | input | 16 | Host data bus |
| devRdy | output | 1 | Device ready (active high internally) |
| dmaReq | output | 1 | DMA request |
| strbOe | output | 1 | Output enable of the device strobe driver |
| wordValid | output | 1 | One-cycle pulse for each captured word |
| wordData | output | 16 | Captured word |
| crcErr | output | 1 | Sticky first-CRC-error flag |
| errCrc | output | 16 | Host CRC value of the first miscompare |
| done | output | 1 | One-cycle pulse at the end of the termination |

## Verification
The hardest state to reach is the window between devRdy falling and dmaReq falling. The trailing-word limit is decided there, and the host may still deliver more edges than that limit. The bench waits until it sees devRdy low and then issues more strobe toggles than the mode permits, all inside the RP_CYC window. The word monitor fails any capture that was not expected, and the CRC comparison shows whether an excess word reached the CRC. The first-error retention needs two bad bursts in one command followed by a clean one after newCmd, and the bench runs that sequence.

// File: rtl/udma_term_pkg.sv
package udma_term_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_HOLD,
    ST_WSTOP,
    ST_WACK,
    ST_REL
  } termState_t;

  typedef struct packed {
    logic seedCrc;
    logic takeWord;
    logic checkCrc;
  } dpCtl_t;

  localparam logic [15:0] CRC_SEED = 16'h4ABA;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  function automatic logic [15:0] crcStep(input logic [15:0] cur, input logic [15:0] word);
    logic [15:0] acc;
    acc = cur;
    for (int b = 15; b >= 0; b--) begin
      acc = {acc[14:0], 1'b0} ^ (CRC_POLY & {16{acc[15] ^ word[b]}});
    end
    return acc;
  endfunction

endpackage

// File: rtl/udmaSync.sv
module udmaSync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncCur,
  output logic [W-1:0] syncPrev
);
  logic [W-1:0] stage1;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[g]   <= 1'b0;
        syncCur[g]  <= 1'b0;
        syncPrev[g] <= 1'b0;
      end else begin
        stage1[g]   <= asyncIn[g];
        syncCur[g]  <= stage1[g];
        syncPrev[g] <= syncCur[g];
      end
    end
  end
endmodule

// File: rtl/udmaTermCtrl.sv
module udmaTermCtrl
  import udma_term_pkg::*;
#(
  parameter int RP_CYC    = 24,
  parameter int REL_CYC   = 4,
  parameter int TRAIL_SLOW = 2,
  parameter int TRAIL_FAST = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   burstStart,
  input  logic   termReq,
  input  logic   fastMode,
  input  logic   strbCur,
  input  logic   strbPrev,
  input  logic   stopCur,
  input  logic   stopPrev,
  input  logic   ackNCur,
  input  logic   ackNPrev,
  output dpCtl_t ctl,
  output logic   devRdy,
  output logic   dmaReq,
  output logic   strbOe,
  output logic   done
);
  localparam int RP_W  = $clog2(RP_CYC + 1);
  localparam int REL_W = $clog2(REL_CYC + 1);
  localparam int TR_W  = $clog2(TRAIL_FAST + 1);

  termState_t state;
  logic [RP_W-1:0]  rpCnt;
  logic [REL_W-1:0] relCnt;
  logic [TR_W-1:0]  trailCnt;
  logic             gotWord;
  logic             strbEdge, stopHigh, ackRise;
  logic [TR_W-1:0]  trailLim;

  assign strbEdge = strbCur ^ strbPrev;
  assign stopHigh = stopCur & stopPrev;
  assign ackRise  = ackNCur & ~ackNPrev;
  assign trailLim = fastMode ? TR_W'(TRAIL_FAST) : TR_W'(TRAIL_SLOW);

  always_comb begin
    ctl = '0;
    ctl.seedCrc = (state == ST_IDLE) && burstStart;
    ctl.takeWord = strbEdge &&
                   ((state == ST_RECV) || ((state == ST_HOLD) && (trailCnt < trailLim)));
    ctl.checkCrc = (state == ST_WACK) && ackRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rpCnt    <= '0;
      relCnt   <= '0;
      trailCnt <= '0;
      gotWord  <= 1'b0;
      devRdy   <= 1'b0;
      dmaReq   <= 1'b0;
      strbOe   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (burstStart) begin
            devRdy  <= 1'b1;
            dmaReq  <= 1'b1;
            strbOe  <= 1'b1;
            gotWord <= 1'b0;
            state   <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (ctl.takeWord) gotWord <= 1'b1;
          if (termReq && gotWord) begin
            devRdy   <= 1'b0;
            rpCnt    <= '0;
            trailCnt <= '0;
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (ctl.takeWord) trailCnt <= trailCnt + 1'b1;
          rpCnt <= rpCnt + 1'b1;
          if (rpCnt == RP_W'(RP_CYC - 1)) begin
            dmaReq <= 1'b0;
            state  <= ST_WSTOP;
          end
        end
        ST_WSTOP: begin
          if (stopHigh) state <= ST_WACK;
        end
        ST_WACK: begin
          if (ackRise) begin
            relCnt <= '0;
            state  <= ST_REL;
          end
        end
        ST_REL: begin
          relCnt <= relCnt + 1'b1;
          if (relCnt == REL_W'(REL_CYC - 1)) begin
            strbOe <= 1'b0;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/udmaTermData.sv
module udmaTermData
  import udma_term_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic        newCmd,
  input  logic [15:0] dataIn,
  output logic        wordValid,
  output logic [15:0] wordData,
  output logic        crcErr,
  output logic [15:0] errCrc
);
  logic [15:0] crcAcc;
  logic        mismatch;

  assign mismatch = ctl.checkCrc && (dataIn != crcAcc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordData  <= '0;
      crcAcc    <= CRC_SEED;
    end else begin
      wordValid <= ctl.takeWord;
      if (ctl.takeWord) wordData <= dataIn;
      if (ctl.seedCrc) crcAcc <= CRC_SEED;
      else if (ctl.takeWord) crcAcc <= crcStep(crcAcc, dataIn);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcErr <= 1'b0;
      errCrc <= '0;
    end else if (newCmd) begin
      crcErr <= 1'b0;
      errCrc <= '0;
    end else if (mismatch && !crcErr) begin
      crcErr <= 1'b1;
      errCrc <= dataIn;
    end
  end
endmodule

// File: rtl/udmaWriteTerm.sv
module udmaWriteTerm
  import udma_term_pkg::*;
#(
  parameter int RP_CYC     = 24,
  parameter int REL_CYC    = 4,
  parameter int TRAIL_SLOW = 2,
  parameter int TRAIL_FAST = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        newCmd,
  input  logic        burstStart,
  input  logic        termReq,
  input  logic        fastMode,
  input  logic        hostStrobe,
  input  logic        hostStop,
  input  logic        hostAckN,
  input  logic [15:0] dataIn,
  output logic        devRdy,
  output logic        dmaReq,
  output logic        strbOe,
  output logic        wordValid,
  output logic [15:0] wordData,
  output logic        crcErr,
  output logic [15:0] errCrc,
  output logic        done
);
  logic [2:0] syncCur, syncPrev;
  dpCtl_t     ctl;

  udmaSync #(.W(3)) i_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({hostAckN, hostStop, hostStrobe}),
    .syncCur(syncCur), .syncPrev(syncPrev)
  );

  udmaTermCtrl #(
    .RP_CYC(RP_CYC), .REL_CYC(REL_CYC),
    .TRAIL_SLOW(TRAIL_SLOW), .TRAIL_FAST(TRAIL_FAST)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .burstStart(burstStart), .termReq(termReq), .fastMode(fastMode),
    .strbCur(syncCur[0]), .strbPrev(syncPrev[0]),
    .stopCur(syncCur[1]), .stopPrev(syncPrev[1]),
    .ackNCur(syncCur[2]), .ackNPrev(syncPrev[2]),
    .ctl(ctl), .devRdy(devRdy), .dmaReq(dmaReq), .strbOe(strbOe), .done(done)
  );

  udmaTermData i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .newCmd(newCmd), .dataIn(dataIn),
    .wordValid(wordValid), .wordData(wordData), .crcErr(crcErr), .errCrc(errCrc)
  );
endmodule

// File: rtl/udmaWriteTermChk.sv
module udmaWriteTermChk #(
  parameter int RP_CYC = 24
) (
  input logic        clk,
  input logic        rstN,
  input logic        newCmd,
  input logic        devRdy,
  input logic        dmaReq,
  input logic        strbOe,
  input logic        wordValid,
  input logic        crcErr,
  input logic [15:0] errCrc,
  input logic        done
);
  logic [15:0] lowCnt;
  logic        seenWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt   <= '0;
      seenWord <= 1'b0;
    end else begin
      lowCnt <= devRdy ? 16'd0 : ((lowCnt == 16'hFFFF) ? lowCnt : lowCnt + 16'd1);
      if (!dmaReq) seenWord <= 1'b0;
      else if (wordValid) seenWord <= 1'b1;
    end
  end

  assert_holdoff_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devRdy) |-> seenWord);

  assert_rdy_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devRdy) |-> (dmaReq && strbOe));

  assert_req_delay_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaReq) |-> (lowCnt >= 16'(RP_CYC)));

  assert_no_rereq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReq && strbOe) |=> !dmaReq);

  assert_no_late_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    !dmaReq |=> !wordValid);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && !newCmd) |=> (crcErr && $stable(errCrc)));

  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!strbOe && !dmaReq && $past(strbOe)));
endmodule

bind udmaWriteTerm udmaWriteTermChk #(.RP_CYC(RP_CYC)) i_chk (
  .clk(clk), .rstN(rstN), .newCmd(newCmd), .devRdy(devRdy), .dmaReq(dmaReq),
  .strbOe(strbOe), .wordValid(wordValid), .crcErr(crcErr), .errCrc(errCrc), .done(done)
);

// File: tb/test_udmaWriteTerm.sv
module test_udmaWriteTerm;
  localparam int RP_CYC  = 24;
  localparam int REL_CYC = 4;

  logic clk = 0, rstN = 0;
  logic newCmd = 0, burstStart = 0, termReq = 0, fastMode = 0;
  logic hostStrobe = 0, hostStop = 0, hostAckN = 1;
  logic [15:0] dataIn = '0;
  logic devRdy, dmaReq, strbOe, wordValid, crcErr, done;
  logic [15:0] wordData, errCrc;

  udmaWriteTerm #(.RP_CYC(RP_CYC), .REL_CYC(REL_CYC)) i_udmaWriteTerm (
    .clk(clk), .rstN(rstN), .newCmd(newCmd), .burstStart(burstStart),
    .termReq(termReq), .fastMode(fastMode), .hostStrobe(hostStrobe),
    .hostStop(hostStop), .hostAckN(hostAckN), .dataIn(dataIn),
    .devRdy(devRdy), .dmaReq(dmaReq), .strbOe(strbOe), .wordValid(wordValid),
    .wordData(wordData), .crcErr(crcErr), .errCrc(errCrc), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, doneCnt = 0;
  logic [15:0] expQ[$];
  logic [15:0] expCrc;
  logic        expErr = 0;
  logic [15:0] expErrVal = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  // word stream reference compared every clock (R10, R3, R5)
  always @(negedge clk) begin
    if (rstN) begin
      if (done) doneCnt++;
      if (wordValid) begin
        if (expQ.size() == 0) check("R3/R5 unexpected word", {16'h0, wordData}, 32'hFFFF_FFFF);
        else check("R10 word data", {16'h0, wordData}, {16'h0, expQ.pop_front()});
      end
    end
  end

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  task automatic sendWord(input logic [15:0] d, input bit accept);
    @(negedge clk);
    dataIn = d;
    if (accept) begin
      expQ.push_back(d);
      expCrc = refCrc(expCrc, d);
    end
    hostStrobe = ~hostStrobe;
    repeat (4) @(negedge clk);
  endtask

  task automatic runBurst(input bit fast, input int nPre, input int nTrail,
                          input bit holdoffTest, input bit bad, input logic [15:0] badVal);
    int tRdy, tReq, w, lim, dc0;
    lim = fast ? 3 : 2;
    @(negedge clk);
    fastMode = fast; hostAckN = 0; hostStop = 0;
    burstStart = 1; expCrc = 16'h4ABA;
    @(negedge clk);
    burstStart = 0;
    repeat (3) @(negedge clk);
    check("R2 ready up in burst", {dmaReq, devRdy}, 2'b11);
    if (holdoffTest) begin
      termReq = 1;
      repeat (8) @(negedge clk);
      check("R1 hold-off without word", devRdy, 1'b1);
    end
    for (int i = 0; i < nPre; i++) sendWord(16'h1000 + 16'(i * 37) + 16'(nTrail), 1);
    termReq = 1;
    w = 0;
    while (devRdy && w < 50) begin @(negedge clk); w++; end
    tRdy = cyc;
    check("R2 ready falls first", {devRdy, dmaReq, strbOe}, 3'b011);
    termReq = 0;
    for (int i = 0; i < nTrail; i++) sendWord(16'hA500 ^ 16'(i * 513), i < lim);
    w = 0;
    while (dmaReq && w < 60) begin @(negedge clk); w++; end
    tReq = cyc;
    check("R4 request delay", (tReq - tRdy) >= RP_CYC, 1'b1);
    hostStop = 1;
    repeat (3) @(negedge clk);
    if (!hostStrobe) hostStrobe = 1;   // no-data strobe edge (R5)
    repeat (6) @(negedge clk);
    check("R4 request stays low", dmaReq, 1'b0);
    check("R5 no words left pending", expQ.size(), 0);
    dataIn = bad ? badVal : expCrc;
    if (bad && !expErr) begin expErr = 1; expErrVal = badVal; end
    repeat (2) @(negedge clk);
    dc0 = doneCnt;
    hostAckN = 1;
    w = 0;
    while (doneCnt == dc0 && w < 40) begin @(negedge clk); w++; end
    check("R8 done pulse seen", doneCnt - dc0, 1);
    check("R8 strobe released", strbOe, 1'b0);
    check("R6/R7 crc error flag", crcErr, expErr);
    check("R7 first error value", errCrc, expErrVal);
    repeat (4) @(negedge clk);
    check("R4 no request after done", dmaReq, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {devRdy, dmaReq, strbOe, wordValid, crcErr, done}, 6'b0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check("R9 idle after reset", {devRdy, dmaReq, strbOe, crcErr}, 4'b0);
    @(negedge clk); newCmd = 1; @(negedge clk); newCmd = 0;
    // slow mode, hold-off, one word then three trailing (one excess), good CRC
    runBurst(0, 1, 3, 1, 0, 16'h0);
    // fast mode, four trailing (one excess), bad CRC -> first error
    runBurst(1, 2, 4, 0, 1, 16'hDEAD);
    // slow mode, second bad CRC: first error value must be kept
    runBurst(0, 2, 1, 0, 1, 16'hBEEF);
    // new command clears the record
    @(negedge clk); newCmd = 1; @(negedge clk); newCmd = 0;
    expErr = 0; expErrVal = 16'h0;
    @(negedge clk);
    check("R7 cleared by new command", {crcErr, errCrc}, 17'h0);
    // fast mode, exactly three trailing words, good CRC
    runBurst(1, 3, 3, 0, 0, 16'h0);
    check("R7 still clear", crcErr, 1'b0);
    finishRun();
  end
endmodule